// File: doc/BRIEF.md
# Serial Receive Status Flags

This block sits between the bit-level receiver of an asynchronous serial port and the CPU. It holds the most recently accepted receive word together with its status flags:

- a data-full flag,
- a second data-full flag that a data read does not clear,
- sticky overrun, framing-error and parity-error flags,
- a data-invalid indication,
- a maskable receive interrupt.

The receive shifter delivers each finished frame as a one-cycle strobe. The strobe carries the word and the frame's framing and parity error indications. The CPU has two controls:

- a read strobe, which consumes the data register;
- a clear-errors write, which drops the sticky error flags.

In LIN operation, a break-detected pulse wipes every receive flag so the port starts clean for the next message. When a frame arrives while the previous word is still unread, the block keeps the earlier word and raises overrun.

All state is registered. Flags change on the clock edge that follows the event that causes them. The interrupt and data-invalid outputs are combinational from the registered flags and the enable input.

Top module: `rx_status_regs`

## Requirements
- R1: After a synchronous active-low reset, rx_data is 0, and full, full_mirror, ovr_err, frm_err, par_err, data_invalid and rx_irq are all 0.
- R2: A frame strobe that does not cause an overrun loads frm_data into rx_data. Both full and full_mirror read 1 on the following cycle.
- R3: A cpu_rd strobe clears full on the next cycle unless a frame is loaded in that same cycle. full_mirror is not affected by cpu_rd.
- R4: A frame strobe while full is 1 and cpu_rd is 0 sets ovr_err. It leaves rx_data unchanged and discards the new word. A frame strobe together with cpu_rd loads the new word with no overrun.
- R5: A frame strobe with frm_ferr=1 sets frm_err, and one with frm_perr=1 sets par_err. This holds whether or not the word is loaded.
- R6: cpu_clr_err=1 clears ovr_err, frm_err and par_err on the next cycle. It leaves full, full_mirror and rx_data unchanged.
- R7: brk_det=1 while lin_mode=1 clears full, full_mirror, ovr_err, frm_err and par_err. brk_det while lin_mode=0 has no effect.
- R8: When a set event and a clear request (cpu_rd, cpu_clr_err or a LIN break) hit the same flag in the same cycle, the flag ends up 1.
- R9: rx_irq is 1 exactly when rie=1 and at least one of full, par_err, ovr_err or frm_err is 1.
- R10: data_invalid is 1 exactly when ovr_err or frm_err is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_vld | input | 1 | One-cycle frame-complete strobe from the receive shifter |
| frm_data | input | DW | Received word, valid with frm_vld |
| frm_ferr | input | 1 | Framing error of the completed frame |
| frm_perr | input | 1 | Parity error of the completed frame |
| cpu_rd | input | 1 | CPU read strobe of the data register |
| cpu_clr_err | input | 1 | CPU write of 1 to the clear-errors control bit |
| rie | input | 1 | Receive interrupt enable |
| lin_mode | input | 1 | LIN operation select |
| brk_det | input | 1 | Break-detected pulse |
| rx_data | output | DW | Data register |
| full | output | 1 | Data-full flag |
| full_mirror | output | 1 | Data-full mirror, not cleared by reads |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing-error flag |
| par_err | output | 1 | Parity-error flag |
| data_invalid | output | 1 | Data register contents invalid |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench aims at the following same-cycle collisions. For each one, the wrong behaviour a faulty design would show is noted.

- **Frame arriving with a read.** A design that tested the stale full flag would flag a false overrun and drop a good word.
- **Frame arriving with a clear-errors write or a LIN break.** A design where the clear won would lose an error or an unread word.
- **Overrun.** A design that overwrote rx_data on overrun would hand the CPU the wrong word. The bench compares the data register after each overrun.
- **Break in and out of LIN mode.** This shows whether the break is wrongly honoured outside LIN.
- **Repeated reads.** These show whether the mirror flag is wrongly cleared by reads.
- **rie toggled over every flag combination.** This catches an interrupt that ignores parity or the enable.

// File: rtl/rxs_pkg.sv
// Package: shared constants for the receive status block.
// Assumes: nothing beyond the standard.
package rxs_pkg;
    // Index of each sticky error flag in the error vector.
    localparam int unsigned ERR_OVR = 0;
    localparam int unsigned ERR_FRM = 1;
    localparam int unsigned ERR_PAR = 2;
    localparam int unsigned N_ERR   = 3;
endpackage

// File: rtl/rxs_sticky.sv
// Module: one sticky status flag with priority set.
// Assumes: set and clear are single-cycle requests; set wins a tie.
module rxs_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/rxs_data_hold.sv
// Module: receive data register with data-full and mirror flags.
// Assumes: frm_vld is a one-cycle strobe; a read in the same cycle as a
// frame consumes the old word, so the new frame is accepted.
module rxs_data_hold #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_vld,
    input  logic [DW-1:0] frm_data,
    input  logic          cpu_rd,
    input  logic          brk_clr,
    output logic [DW-1:0] data_o,
    output logic          full_o,
    output logic          mirror_o,
    output logic          overrun_o
);
    logic [DW-1:0] data_q;
    logic          full_q;
    logic          mirror_q;
    logic          load;

    // Overrun: unread word still present and not being read now.
    assign overrun_o = frm_vld & full_q & ~cpu_rd;
    assign load      = frm_vld & ~overrun_o;

    // Data register: captures accepted frames only.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= frm_data;
    end

    // Primary full flag: set on load, cleared by read or LIN break.
    always_ff @(posedge clk) begin
        if (!rst_n)                full_q <= 1'b0;
        else if (load)             full_q <= 1'b1;
        else if (cpu_rd | brk_clr) full_q <= 1'b0;
    end

    // Mirror full flag: set on load, cleared only by LIN break.
    always_ff @(posedge clk) begin
        if (!rst_n)       mirror_q <= 1'b0;
        else if (load)    mirror_q <= 1'b1;
        else if (brk_clr) mirror_q <= 1'b0;
    end

    assign data_o   = data_q;
    assign full_o   = full_q;
    assign mirror_o = mirror_q;

    p_load_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !overrun_o) |=> (full_o && mirror_o));
    p_overrun_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> $stable(data_o));
    p_read_clears_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !frm_vld) |=> !full_o);
    p_mirror_ignores_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror_o && !brk_clr) |=> mirror_o);
    p_full_implies_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> mirror_o);
endmodule

// File: rtl/rx_status_regs.sv
// Module: receive data register, status flags and receive interrupt of an
// asynchronous serial port.
// Assumes: all strobes are synchronous to clk; break clearing applies only
// while lin_mode is 1; set events beat clears in the same cycle.
module rx_status_regs #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_vld,
    input  logic [DW-1:0] frm_data,
    input  logic          frm_ferr,
    input  logic          frm_perr,
    input  logic          cpu_rd,
    input  logic          cpu_clr_err,
    input  logic          rie,
    input  logic          lin_mode,
    input  logic          brk_det,
    output logic [DW-1:0] rx_data,
    output logic          full,
    output logic          full_mirror,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          par_err,
    output logic          data_invalid,
    output logic          rx_irq
);
    import rxs_pkg::*;

    logic             brk_clr;
    logic             overrun;
    logic [N_ERR-1:0] err_set;
    logic [N_ERR-1:0] err_q;

    // Break clearing is honoured only in LIN operation.
    assign brk_clr = lin_mode & brk_det;

    rxs_data_hold #(.DW(DW)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_vld   (frm_vld),
        .frm_data  (frm_data),
        .cpu_rd    (cpu_rd),
        .brk_clr   (brk_clr),
        .data_o    (rx_data),
        .full_o    (full),
        .mirror_o  (full_mirror),
        .overrun_o (overrun)
    );

    // Set sources of the sticky error flags.
    always_comb begin
        err_set          = '0;
        err_set[ERR_OVR] = overrun;
        err_set[ERR_FRM] = frm_vld & frm_ferr;
        err_set[ERR_PAR] = frm_vld & frm_perr;
    end

    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        rxs_sticky i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (err_set[g]),
            .clr_i (cpu_clr_err | brk_clr),
            .q_o   (err_q[g])
        );
    end

    assign ovr_err      = err_q[ERR_OVR];
    assign frm_err      = err_q[ERR_FRM];
    assign par_err      = err_q[ERR_PAR];
    assign data_invalid = ovr_err | frm_err;
    assign rx_irq       = rie & (full | (|err_q));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rie |-> !rx_irq);
    p_irq_on_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rie && full) |-> rx_irq);
    p_invalid_on_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err || frm_err) |-> data_invalid);
    p_break_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && brk_det && !frm_vld) |=> (!full && !full_mirror && !ovr_err && !frm_err && !par_err));
endmodule

// File: tb/test_rx_status_regs.sv
`timescale 1ns/1ps
module test_rx_status_regs;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frm_vld, frm_ferr, frm_perr, cpu_rd, cpu_clr_err, rie, lin_mode, brk_det;
    logic [DW-1:0] frm_data;
    logic [DW-1:0] rx_data;
    logic          full, full_mirror, ovr_err, frm_err, par_err, data_invalid, rx_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench model state.
    logic [DW-1:0] m_data;
    logic          m_full, m_mir, m_ore, m_fre, m_pe;

    always #4 clk = ~clk;

    rx_status_regs #(.DW(DW)) i_rx_status_regs (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_data(frm_data),
        .frm_ferr(frm_ferr), .frm_perr(frm_perr), .cpu_rd(cpu_rd),
        .cpu_clr_err(cpu_clr_err), .rie(rie), .lin_mode(lin_mode), .brk_det(brk_det),
        .rx_data(rx_data), .full(full), .full_mirror(full_mirror), .ovr_err(ovr_err),
        .frm_err(frm_err), .par_err(par_err), .data_invalid(data_invalid), .rx_irq(rx_irq)
    );

    function automatic logic exp_irq(logic en, logic f, logic p, logic o, logic fr);
        return en & (f | p | o | fr);
    endfunction

    function automatic logic exp_inv(logic o, logic fr);
        return o | fr;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string ctx);
        chk({ctx, " R2 rx_data"},       32'(rx_data),     32'(m_data));
        chk({ctx, " R3 full"},          32'(full),        32'(m_full));
        chk({ctx, " R3 full_mirror"},   32'(full_mirror), 32'(m_mir));
        chk({ctx, " R4 ovr_err"},       32'(ovr_err),     32'(m_ore));
        chk({ctx, " R5 frm_err"},       32'(frm_err),     32'(m_fre));
        chk({ctx, " R5 par_err"},       32'(par_err),     32'(m_pe));
        chk({ctx, " R10 data_invalid"}, 32'(data_invalid), 32'(exp_inv(m_ore, m_fre)));
        chk({ctx, " R9 rx_irq"},        32'(rx_irq),      32'(exp_irq(rie, m_full, m_pe, m_ore, m_fre)));
    endtask

    // One clock cycle: drive at negedge, update model, compare after the edge.
    task automatic cyc(string ctx, logic v, logic [DW-1:0] d, logic fe, logic pe,
                       logic rd, logic clr, logic en, logic lin, logic brk);
        logic ovr, ld, bclr;
        @(negedge clk);
        frm_vld = v; frm_data = d; frm_ferr = fe; frm_perr = pe; cpu_rd = rd;
        cpu_clr_err = clr; rie = en; lin_mode = lin; brk_det = brk;
        bclr = lin & brk;
        ovr  = v & m_full & ~rd;
        ld   = v & ~ovr;
        @(posedge clk);
        #2;
        if (ld) m_data = d;
        m_full = ld ? 1'b1 : ((rd | bclr) ? 1'b0 : m_full);
        m_mir  = ld ? 1'b1 : (bclr ? 1'b0 : m_mir);
        m_ore  = ovr ? 1'b1 : ((clr | bclr) ? 1'b0 : m_ore);
        m_fre  = (v & fe) ? 1'b1 : ((clr | bclr) ? 1'b0 : m_fre);
        m_pe   = (v & pe) ? 1'b1 : ((clr | bclr) ? 1'b0 : m_pe);
        check_all(ctx);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; frm_vld = 0; frm_data = '0; frm_ferr = 0; frm_perr = 0;
        cpu_rd = 0; cpu_clr_err = 0; rie = 1; lin_mode = 0; brk_det = 0;
        m_data = '0; m_full = 0; m_mir = 0; m_ore = 0; m_fre = 0; m_pe = 0;
        repeat (3) @(posedge clk);
        #2;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases.
        cyc("R9 idle", 0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
        cyc("R2 load", 1, 8'hA5, 0, 0, 0, 0, 1, 0, 0);
        cyc("R3 read", 0, 8'h00, 0, 0, 1, 0, 1, 0, 0);
        cyc("R2 load2", 1, 8'h3C, 0, 0, 0, 0, 0, 0, 0);
        cyc("R4 overrun", 1, 8'hFF, 0, 0, 0, 0, 1, 0, 0);
        cyc("R4 read+frame", 1, 8'h77, 0, 0, 1, 0, 1, 0, 0);
        cyc("R6 clear", 0, 8'h00, 0, 0, 0, 1, 1, 0, 0);
        cyc("R5 ferr", 1, 8'h11, 1, 0, 1, 0, 1, 0, 0);
        cyc("R5 perr", 1, 8'h22, 0, 1, 1, 0, 1, 0, 0);
        cyc("R8 clear vs set", 1, 8'h33, 1, 1, 0, 1, 1, 0, 0);
        cyc("R7 break no LIN", 0, 8'h00, 0, 0, 0, 0, 1, 0, 1);
        cyc("R7 break LIN", 0, 8'h00, 0, 0, 0, 0, 1, 1, 1);
        cyc("R8 break vs frame", 1, 8'h44, 1, 0, 0, 0, 1, 1, 1);
        cyc("R8 read vs frame", 1, 8'h55, 0, 0, 1, 0, 1, 0, 0);
        cyc("R9 masked", 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3 read again", 0, 8'h00, 0, 0, 1, 0, 1, 0, 0);
        cyc("R9 par only", 1, 8'h66, 0, 1, 0, 0, 1, 0, 0);
        cyc("R3 read keeps mirror", 0, 8'h00, 0, 0, 1, 0, 1, 0, 0);

        // Constrained random traffic.
        for (int i = 0; i < 3000; i++) begin
            cyc("random",
                ($urandom % 3) == 0, DW'($urandom),
                ($urandom % 8) == 0, ($urandom % 8) == 0,
                ($urandom % 4) == 0, ($urandom % 10) == 0,
                ($urandom % 4) != 0, ($urandom % 2) == 0,
                ($urandom % 16) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule